// File: doc/BRIEF.md
# Masked Vectored Priority Interrupt Controller

This block gathers four interrupt request lines from peripherals. A rising edge on a request line latches a pending flag for that source. Each flag is gated by its own mask bit. Among the pending and unmasked sources, a fixed priority chooses one: source 0 is the most urgent and source 3 the least. The block reports whether any gated request exists. It also forms an 8-bit vector address, whose upper bits come from a base parameter and whose two lowest bits hold the winner's code.

Software drives a simple write port with a 2-bit operation code and a 4-bit data field. Through it, software sets or clears mask bits, clears pending flags, and turns the global interrupt enable on or off. The CPU sees a single request output. At an instruction boundary it raises the take input for one cycle. During that cycle the vector is driven, with its own output-enable. The take also drops the global enable, so no further request is raised until software enables again. All pins are plain control and status signals. There is no streamed data and so no valid/ready handshake.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending flags, all mask bits and the global enable are 0. As a result, irq_o, ist_o and vec_oe_o are 0 and vec_o is all zeros.
- R2: A 0-to-1 change on req_i[k] sets pending flag k at the next clock edge. A request held high does not set the flag again after it has been cleared.
- R3: A write with wr_addr_i = 2 clears every pending flag whose wr_data_i bit is 1, and leaves all other flags unchanged. A pending flag otherwise stays set.
- R4: If a rising request and a clear for the same flag occur in the same cycle, the flag ends up set.
- R5: A write with wr_addr_i = 0 sets the mask bits selected by wr_data_i. A write with wr_addr_i = 1 clears them. Mask bit 1 means the source is allowed through. ist_o is 1 exactly when some pending flag has its mask bit set.
- R6: Among the pending, unmasked sources, the lowest index wins. During a take, vec_o[1:0] holds the winner's index in binary (00 for source 0 through 11 for source 3), and vec_o[7:2] equals VEC_BASE[7:2].
- R7: A write with wr_addr_i = 3 loads the global enable from wr_data_i[0]. irq_o is the AND of the global enable and ist_o.
- R8: vec_oe_o equals take_i. vec_o is all zeros whenever take_i is 0.
- R9: take_i clears the global enable at the next edge. If take_i coincides with an enable write, the enable ends up cleared.
- R10: During a take with no pending unmasked source, vec_o[1:0] is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Interrupt request lines, edge-detected |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Operation: 0 mask set, 1 mask clear, 2 pending clear, 3 global enable |
| wr_data_i | input | 4 | Per-source bit select; bit 0 is the enable value for operation 3 |
| take_i | input | 1 | CPU acknowledge, one cycle at an instruction boundary |
| irq_o | output | 1 | Interrupt request to the CPU |
| ist_o | output | 1 | Some pending source is unmasked |
| vec_oe_o | output | 1 | Vector output enable |
| vec_o | output | 8 | Vector address, driven only during a take |

## Verification
Two collisions matter. The first is a request edge arriving in the same cycle as a software clear of that flag. The bench provokes it by dropping a request line and then raising it together with a pending-clear write, and it expects ist_o to stay high afterwards. The second is a take landing in the same cycle as an enable write. The bench drives both together and expects irq_o to be low on the next cycle. Random traffic then mixes both collisions with mask changes. A behavioural model, compared every cycle, judges the outcome.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N = 4;
  localparam int IDX_W = 2;

  typedef enum logic [1:0] {
    OP_MASK_SET = 2'd0,
    OP_MASK_CLR = 2'd1,
    OP_PEND_CLR = 2'd2,
    OP_GLOBAL   = 2'd3
  } irq_op_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic rise;
    assign rise = req_i[k] & ~req_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[k]  <= 1'b0;
        pend_o[k] <= 1'b0;
      end else begin
        req_q[k] <= req_i[k];
        // a new edge outranks a simultaneous software clear
        if (rise)          pend_o[k] <= 1'b1;
        else if (clr_i[k]) pend_o[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
  import irq_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  irq_op_e      op_i,
  input  logic [N-1:0] data_i,
  input  logic         take_i,
  output logic [N-1:0] mask_o,
  output logic         ien_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (wr_en_i) begin
      case (op_i)
        OP_MASK_SET: mask_o <= mask_o | data_i;
        OP_MASK_CLR: mask_o <= mask_o & ~data_i;
        default:     mask_o <= mask_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              ien_o <= 1'b0;
    else if (take_i)                         ien_o <= 1'b0;
    else if (wr_en_i && op_i == OP_GLOBAL)   ien_o <= data_i[0];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic [SRC_N-1:0] gated_i,
  output logic [IDX_W-1:0] code_o,
  output logic             any_o
);
  logic hi_bit, lo_bit;

  always_comb begin
    hi_bit = ~gated_i[0] & ~gated_i[1];
    lo_bit = (~gated_i[0] & gated_i[1]) | (~gated_i[0] & ~gated_i[2]);
    code_o = {hi_bit, lo_bit};
    any_o  = |gated_i;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [SRC_N-1:0] wr_data_i,
  input  logic             take_i,
  output logic             irq_o,
  output logic             ist_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_o
);
  irq_op_e          op;
  logic [SRC_N-1:0] clr_sel;
  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] mask_q;
  logic             ien_q;
  logic [IDX_W-1:0] code;
  logic             any_req;
  logic [VEC_W-1:0] vec_full;

  assign op      = irq_op_e'(wr_addr_i);
  assign clr_sel = (wr_en_i && op == OP_PEND_CLR) ? wr_data_i : '0;

  irq_pend_bank #(.N(SRC_N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (clr_sel),
    .pend_o (pend_q)
  );

  irq_gate_ctl #(.N(SRC_N)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .op_i    (op),
    .data_i  (wr_data_i),
    .take_i  (take_i),
    .mask_o  (mask_q),
    .ien_o   (ien_q)
  );

  irq_prio_enc u_enc (
    .gated_i (pend_q & mask_q),
    .code_o  (code),
    .any_o   (any_req)
  );

  assign vec_full = {VEC_BASE[VEC_W-1:IDX_W], code};
  assign ist_o    = any_req;
  assign irq_o    = ien_q & any_req;
  assign vec_oe_o = take_i;
  assign vec_o    = take_i ? vec_full : '0;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] req_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [SRC_N-1:0] wr_data_i,
  input logic             take_i,
  input logic             irq_o,
  input logic             ist_o,
  input logic             vec_oe_o,
  input logic [7:0]       vec_o,
  input logic [SRC_N-1:0] pend_q,
  input logic [SRC_N-1:0] mask_q
);
  logic [SRC_N-1:0] clr_bits;
  assign clr_bits = (wr_en_i && wr_addr_i == 2'd2) ? wr_data_i : '0;

  // R2
  pend_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(req_i)) == '0));

  // R3
  pend_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q & $past(pend_q) & ~$past(clr_bits)) == '0));

  // R7
  irq_needs_ist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ist_o);

  // R8
  vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |-> (vec_o == 8'h00 && !vec_oe_o));

  // R9
  take_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !irq_o);

  // R6
  vec_points_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ist_o) |-> (pend_q[vec_o[1:0]] && mask_q[vec_o[1:0]]));
endmodule

bind irq_vector_ctrl irq_vector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .take_i    (take_i),
  .irq_o     (irq_o),
  .ist_o     (ist_o),
  .vec_oe_o  (vec_oe_o),
  .vec_o     (vec_o),
  .pend_q    (pend_q),
  .mask_q    (mask_q)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  localparam logic [7:0] BASE = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       wen = 1'b0;
  logic [1:0] waddr = '0;
  logic [3:0] wdata = '0;
  logic       take = 1'b0;
  logic       irq, ist, voe;
  logic [7:0] vec;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference state
  bit [3:0] m_pend, m_mask, m_prev;
  bit       m_ien;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.VEC_BASE(BASE)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wen), .wr_addr_i(waddr),
    .wr_data_i(wdata), .take_i(take), .irq_o(irq), .ist_o(ist),
    .vec_oe_o(voe), .vec_o(vec)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_prev = '0; m_ien = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (req[i] && !m_prev[i]) m_pend[i] = 1;
        else if (wen && waddr == 2 && wdata[i]) m_pend[i] = 0;
      end
      m_prev = req;
      if (wen && waddr == 0) m_mask = m_mask | wdata;
      if (wen && waddr == 1) m_mask = m_mask & ~wdata;
      if (take) m_ien = 0;
      else if (wen && waddr == 3) m_ien = wdata[0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic model_compare();
    int idx = 3;
    bit any = 0;
    int ev;
    for (int i = 3; i >= 0; i--)
      if (m_pend[i] && m_mask[i]) begin idx = i; any = 1; end
    ev = take ? ((BASE & 8'hFC) | idx) : 0;
    chk("R5 ist", ist, any);
    chk("R7 irq", irq, m_ien && any);
    chk("R8 vec_oe", voe, take);
    chk("R6 vec", vec, ev);
  endtask

  task automatic cyc(logic [3:0] r, logic we, logic [1:0] a, logic [3:0] d, logic t);
    @(negedge clk);
    req = r; wen = we; waddr = a; wdata = d; take = t;
    #2;
    if (rst_n) model_compare();
  endtask

  initial begin
    #(20ns * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) cyc(4'h0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4'h0, 0, 0, 0, 0);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 ist", ist, 0);
    chk("R1 voe", voe, 0); chk("R1 vec", vec, 0);
    cyc(4'h0, 0, 0, 0, 1);
    chk("R10 empty vector", vec, 8'h43);

    cyc(4'h0, 1, 0, 4'hF, 0);        // unmask all
    cyc(4'h0, 1, 3, 4'h1, 0);        // enable
    cyc(4'h4, 0, 0, 0, 0);           // rise on source 2
    cyc(4'h4, 0, 0, 0, 0);
    chk("R2 edge sets pending", ist, 1);
    chk("R7 irq raised", irq, 1);
    cyc(4'h4, 0, 0, 0, 1);
    chk("R6 vector source 2", vec, 8'h42);
    chk("R8 oe during take", voe, 1);
    cyc(4'h4, 0, 0, 0, 0);
    chk("R9 take drops irq", irq, 0);
    cyc(4'h4, 1, 2, 4'h4, 0);        // clear pending 2, level still high
    cyc(4'h4, 0, 0, 0, 0);
    cyc(4'h4, 0, 0, 0, 0);
    chk("R3 clear, R2 no retrigger", ist, 0);

    cyc(4'hA, 0, 0, 0, 0);           // sources 1 and 3 rise
    cyc(4'hA, 0, 0, 0, 1);
    chk("R6 vector source 1 wins", vec, 8'h41);
    cyc(4'hA, 1, 1, 4'h2, 0);        // mask source 1
    cyc(4'hA, 0, 0, 0, 1);
    chk("R5 masked source skipped", vec, 8'h43);
    cyc(4'hA, 1, 2, 4'h8, 0);        // clear pending 3
    cyc(4'hA, 0, 0, 0, 0);
    chk("R5 only masked pending left", ist, 0);
    cyc(4'hA, 1, 0, 4'h2, 0);        // unmask source 1 again
    cyc(4'hA, 0, 0, 0, 0);
    chk("R3 pending 1 kept", ist, 1);
    cyc(4'h0, 1, 2, 4'h2, 0);
    cyc(4'h0, 0, 0, 0, 0);
    cyc(4'h1, 1, 2, 4'h1, 0);        // rise on 0 with clear of 0
    cyc(4'h1, 0, 0, 0, 0);
    chk("R4 set wins over clear", ist, 1);
    cyc(4'h1, 1, 3, 4'h1, 1);        // take with enable
    cyc(4'h1, 0, 0, 0, 0);
    chk("R9 take beats enable", irq, 0);
    cyc(4'h1, 1, 3, 4'h1, 0);
    cyc(4'h1, 0, 0, 0, 0);
    chk("R7 re-enabled", irq, 1);
    cyc(4'h1, 1, 3, 4'h0, 0);
    cyc(4'h1, 0, 0, 0, 0);
    chk("R7 disabled", irq, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r = req;
      if ($urandom_range(0, 3) == 0) r = r ^ 4'($urandom_range(0, 15));
      cyc(r, ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)),
          4'($urandom_range(0, 15)), ($urandom_range(0, 5) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule